// File: doc/BRIEF.md
# Clock-Generator Configuration Serial Slave

This block is the configuration front end of a clock generator. It listens on a two-wire serial bus (open-drain clock and data lines, standard mode, 100 kbit/s or slower) that it oversamples with the core clock. It holds a small bank of configuration bytes. Those bytes drive the frequency-source choice, the software frequency code, spread-spectrum enable, a global output tristate and the per-output clock enables. The block never stretches the bus clock and does not arbitrate between several masters.

A write transaction is fixed in shape. The slave address is followed by two bytes whose values do not matter, a command byte and a count byte. The data bytes that come after them land in register 0, then 1, and so on upward. The master may stop after any whole byte. A read transaction returns a count byte and then every register in turn. Two fields read back differently from what was written: the frequency bits of register 0 while hardware straps are in use, and the strap field of the last register. The strap inputs are captured once, on the first clock edge after reset, and that captured value is held until the next reset.

All configuration outputs are plain levels that change one core clock after a byte is committed. The serial pins are the only data path, so the block has no stream handshake.

Top module: `cfgslv_top`

## Requirements
- R1: The slave acknowledges the write address 0xD2 and the read address 0xD3 by pulling SDA low during the ninth SCL clock of the address byte.
- R2: Any other address byte is not acknowledged, and SDA stays released for every bit of the rest of that transaction, up to the next START or STOP.
- R3: In a write, the first two bytes after the address are acknowledged and change no register. Each later byte is acknowledged and stored, the first in register 0 and each following one in the next register up.
- R4: A STOP after any complete byte keeps every byte already acknowledged. A byte cut short by a START or STOP is never stored.
- R5: A read returns first the count byte, equal to the number of registers (6), and then the readback of registers 0 to 5 in ascending order. Any byte the master clocks after register 5 reads as 0xFF.
- R6: After reset, register 0 is 0x00, registers 1 to 4 are 0xFF and register 5 is 0x06.
- R7: Register 0 bit 3 selects the frequency source, and freq_from_regs equals that bit. When the bit is 0, freq_code is {0, captured straps}. When it is 1, freq_code is {bit7, bit2, bit6, bit5, bit4} of register 0. Strap changes after capture have no effect.
- R8: spread_en equals register 0 bit 1, and outputs_hiz equals register 0 bit 0.
- R9: When register 0 bit 3 is 0, the readback of register 0 shows the 5-bit revision code in place of the frequency bits: code bit 4 in bit 7, code bit 3 in bit 2, and code bits 2:0 in bits 6:4. Bits 3, 1 and 0 read as stored. When bit 3 is 1, the register reads back exactly as written.
- R10: The readback of register 5 carries the inverted captured straps in bits 7:4 (strap bit 3 in bit 7) and the stored bits 3:0 in bits 3:0.
- R11: out_enable is registers 4..1 concatenated, with register 1 in bits 7:0. aux_cfg is the whole stored register 5. These outputs change only when a byte is committed.
- R12: Write data bytes beyond register 5 are acknowledged and discarded.
- R13: A master NACK during a read ends the slave's transmission, and SDA stays released until the next START or STOP.
- R14: The slave changes SDA only while SCL is low. The one exception is that it releases SDA when it detects a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| strap_i | input | 4 | Frequency strap pins, captured on the first clock after reset |
| sda_drive_low | output | 1 | 1 pulls SDA low; 0 releases it |
| freq_code | output | 5 | Effective frequency code |
| freq_from_regs | output | 1 | 1 when the software code is selected |
| spread_en | output | 1 | Spread-spectrum enable |
| outputs_hiz | output | 1 | Tristate all clock outputs |
| out_enable | output | 32 | Per-output clock enables from registers 1 to 4 |
| aux_cfg | output | 8 | Stored content of register 5 |

## Verification
The hardest state to reach from the pins is a byte cut short: the slave holds a few shifted bits of a data byte when the bus gives a START or STOP instead of the remaining clocks. The bench gets there by sending a valid address, command and count, and then only three or four data bits, followed either by a STOP or by a repeated START into a read. The registers must then read back unchanged. A second hard state is the read after a master NACK, in which the bench keeps clocking SCL. The bench also sends an unknown address followed by a data byte of zeros, so that any stray drive on SDA would show up.

// File: rtl/cfgslv_pkg.sv
package cfgslv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_IGNORE
  } bus_st_e;
endpackage

// File: rtl/cfgslv_line_sync.sv
module cfgslv_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] scl_ff, sda_ff;
  logic         scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[MSB-1:0], scl_i};
      sda_ff <= {sda_ff[MSB-1:0], sda_i};
      scl_q  <= scl_ff[MSB];
      sda_q  <= sda_ff[MSB];
    end
  end

  assign scl_lvl   = scl_ff[MSB];
  assign sda_lvl   = sda_ff[MSB];
  assign scl_rise  = scl_lvl & ~scl_q;
  assign scl_fall  = ~scl_lvl & scl_q;
  assign start_det = scl_lvl & scl_q & sda_q & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/cfgslv_xfer_fsm.sv
module cfgslv_xfer_fsm
  import cfgslv_pkg::*;
#(
  parameter logic [7:0] WR_ADDR   = 8'hD2,
  parameter logic [7:0] RD_ADDR   = 8'hD3,
  parameter int         NUM_BYTES = 6,
  parameter int         IDX_W     = 3,
  parameter int         POS_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_lvl,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic [7:0]       rd_data,
  output logic [POS_W-1:0] rd_sel,
  output logic             sda_drive_low,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_addr,
  output logic [7:0]       wr_data
);
  localparam logic [POS_W-1:0] POS_MAX   = POS_W'(NUM_BYTES + 2);
  localparam logic [POS_W-1:0] SKIP_HDR  = POS_W'(2);

  bus_st_e          state;
  logic [3:0]       bitcnt;
  logic [7:0]       shreg;
  logic             is_addr;
  logic             rd_mode;
  logic             nack_q;
  logic [POS_W-1:0] pos;
  logic [POS_W-1:0] pos_next;

  assign pos_next = (pos == POS_MAX) ? pos : pos + POS_W'(1);
  assign rd_sel   = (state == ST_MACK) ? pos_next : pos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= ST_IDLE;
      bitcnt        <= 4'd0;
      shreg         <= 8'h00;
      is_addr       <= 1'b0;
      rd_mode       <= 1'b0;
      nack_q        <= 1'b0;
      pos           <= '0;
      sda_drive_low <= 1'b0;
      wr_en         <= 1'b0;
      wr_addr       <= '0;
      wr_data       <= 8'h00;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        state         <= ST_RX;
        bitcnt        <= 4'd0;
        is_addr       <= 1'b1;
        pos           <= '0;
        sda_drive_low <= 1'b0;
      end else if (stop_det) begin
        state         <= ST_IDLE;
        sda_drive_low <= 1'b0;
      end else begin
        unique case (state)
          ST_RX: begin
            if (scl_rise && bitcnt < 4'd8) begin
              shreg  <= {shreg[6:0], sda_lvl};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              if (is_addr) begin
                is_addr <= 1'b0;
                if (shreg == WR_ADDR) begin
                  rd_mode       <= 1'b0;
                  sda_drive_low <= 1'b1;
                  state         <= ST_ACK;
                end else if (shreg == RD_ADDR) begin
                  rd_mode       <= 1'b1;
                  sda_drive_low <= 1'b1;
                  state         <= ST_ACK;
                end else begin
                  state <= ST_IGNORE;
                end
              end else begin
                sda_drive_low <= 1'b1;
                state         <= ST_ACK;
                if (pos >= SKIP_HDR && pos < POS_MAX) begin
                  wr_en   <= 1'b1;
                  wr_addr <= IDX_W'(pos - SKIP_HDR);
                  wr_data <= shreg;
                end
                pos <= pos_next;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              bitcnt <= 4'd0;
              if (rd_mode) begin
                shreg         <= rd_data;
                sda_drive_low <= ~rd_data[7];
                state         <= ST_TX;
              end else begin
                sda_drive_low <= 1'b0;
                state         <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                sda_drive_low <= 1'b0;
                state         <= ST_MACK;
              end else begin
                shreg         <= {shreg[6:0], 1'b0};
                sda_drive_low <= ~shreg[6];
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              nack_q <= sda_lvl;
            end else if (scl_fall) begin
              if (nack_q) begin
                state <= ST_IGNORE;
              end else begin
                pos           <= pos_next;
                bitcnt        <= 4'd0;
                shreg         <= rd_data;
                sda_drive_low <= ~rd_data[7];
                state         <= ST_TX;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfgslv_reg_bank.sv
module cfgslv_reg_bank #(
  parameter int         NUM_EN      = 4,
  parameter int         STRAP_W     = 4,
  parameter logic [4:0] REV_CODE    = 5'b00010,
  parameter logic [7:0] AUX_DEFAULT = 8'h06,
  parameter int         NUM_BYTES   = NUM_EN + 2,
  parameter int         IDX_W       = 3,
  parameter int         POS_W       = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [STRAP_W-1:0]    strap_i,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_addr,
  input  logic [7:0]            wr_data,
  input  logic [POS_W-1:0]      rd_sel,
  output logic [7:0]            rd_data,
  output logic [STRAP_W:0]      freq_code,
  output logic                  freq_from_regs,
  output logic                  spread_en,
  output logic                  outputs_hiz,
  output logic [NUM_EN*8-1:0]   out_enable,
  output logic [7:0]            aux_cfg
);
  localparam int LAST = NUM_BYTES - 1;

  logic [7:0]         regs [NUM_BYTES];
  logic [STRAP_W-1:0] strap_q;
  logic               strap_done;
  logic [7:0]         r0_view;
  logic [7:0]         aux_view;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_q    <= '0;
      strap_done <= 1'b0;
    end else if (!strap_done) begin
      strap_q    <= strap_i;
      strap_done <= 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_byte
    localparam logic [7:0] DEF = (g == 0)    ? 8'h00 :
                                 (g == LAST) ? AUX_DEFAULT : 8'hFF;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs[g] <= DEF;
      else if (wr_en && wr_addr == IDX_W'(g)) regs[g] <= wr_data;
    end
  end

  for (genvar g = 0; g < NUM_EN; g++) begin : g_en
    assign out_enable[g*8 +: 8] = regs[g+1];
  end

  assign freq_from_regs = regs[0][3];
  assign spread_en      = regs[0][1];
  assign outputs_hiz    = regs[0][0];
  assign aux_cfg        = regs[LAST];
  assign freq_code      = regs[0][3]
                        ? (STRAP_W+1)'({regs[0][7], regs[0][2], regs[0][6:4]})
                        : {1'b0, strap_q};

  assign r0_view  = regs[0][3] ? regs[0]
                  : {REV_CODE[4], REV_CODE[2:0], regs[0][3], REV_CODE[3], regs[0][1:0]};
  assign aux_view = {~strap_q, regs[LAST][7-STRAP_W:0]};

  always_comb begin
    rd_data = 8'hFF;
    if (rd_sel == '0) begin
      rd_data = 8'(NUM_BYTES);
    end else if (rd_sel == POS_W'(1)) begin
      rd_data = r0_view;
    end else if (rd_sel == POS_W'(NUM_BYTES)) begin
      rd_data = aux_view;
    end else begin
      for (int i = 1; i < LAST; i++) begin
        if (rd_sel == POS_W'(i + 1)) rd_data = regs[i];
      end
    end
  end
endmodule

// File: rtl/cfgslv_top.sv
module cfgslv_top #(
  parameter logic [7:0] WR_ADDR     = 8'hD2,
  parameter logic [7:0] RD_ADDR     = 8'hD3,
  parameter int         NUM_EN      = 4,
  parameter int         STRAP_W     = 4,
  parameter logic [4:0] REV_CODE    = 5'b00010,
  parameter logic [7:0] AUX_DEFAULT = 8'h06,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl_i,
  input  logic                sda_i,
  input  logic [STRAP_W-1:0]  strap_i,
  output logic                sda_drive_low,
  output logic [STRAP_W:0]    freq_code,
  output logic                freq_from_regs,
  output logic                spread_en,
  output logic                outputs_hiz,
  output logic [NUM_EN*8-1:0] out_enable,
  output logic [7:0]          aux_cfg
);
  localparam int NUM_BYTES = NUM_EN + 2;
  localparam int IDX_W     = $clog2(NUM_BYTES);
  localparam int POS_W     = $clog2(NUM_BYTES + 3);

  logic             scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic             wr_en;
  logic [IDX_W-1:0] wr_addr;
  logic [7:0]       wr_data;
  logic [POS_W-1:0] rd_sel;
  logic [7:0]       rd_data;

  cfgslv_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  cfgslv_xfer_fsm #(
    .WR_ADDR(WR_ADDR), .RD_ADDR(RD_ADDR), .NUM_BYTES(NUM_BYTES),
    .IDX_W(IDX_W), .POS_W(POS_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .rd_data(rd_data), .rd_sel(rd_sel), .sda_drive_low(sda_drive_low),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  cfgslv_reg_bank #(
    .NUM_EN(NUM_EN), .STRAP_W(STRAP_W), .REV_CODE(REV_CODE),
    .AUX_DEFAULT(AUX_DEFAULT), .NUM_BYTES(NUM_BYTES), .IDX_W(IDX_W),
    .POS_W(POS_W)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .strap_i(strap_i), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .freq_code(freq_code), .freq_from_regs(freq_from_regs),
    .spread_en(spread_en), .outputs_hiz(outputs_hiz),
    .out_enable(out_enable), .aux_cfg(aux_cfg)
  );
endmodule

// File: rtl/cfgslv_checker.sv
module cfgslv_checker #(
  parameter int NUM_BYTES = 6,
  parameter int IDX_W     = 3,
  parameter int EN_W      = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_lvl,
  input logic             start_det,
  input logic             stop_det,
  input logic             sda_drive_low,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_addr,
  input logic [EN_W-1:0]  out_enable
);
  // R14: the data line moves only after a low clock level or a bus condition
  a_r14_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_drive_low != $past(sda_drive_low))
      |-> (!$past(scl_lvl) || $past(start_det) || $past(stop_det)));

  // R2: a START always leaves the line released
  a_r2_release_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_drive_low);

  // R4: a STOP always leaves the line released
  a_r4_release_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_drive_low);

  // R11: enables move only in the cycle after a commit
  a_r11_enables_only_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(out_enable));

  // R12: no commit targets a register that does not exist
  a_r12_commit_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_addr) < NUM_BYTES));
endmodule

bind cfgslv_top cfgslv_checker #(
  .NUM_BYTES(NUM_BYTES), .IDX_W(IDX_W), .EN_W(NUM_EN*8)
) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .start_det(start_det),
  .stop_det(stop_det), .sda_drive_low(sda_drive_low), .wr_en(wr_en),
  .wr_addr(wr_addr), .out_enable(out_enable)
);

// File: tb/cfgslv_top_tb.sv
module cfgslv_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int H          = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        m_scl = 1'b1, m_sda = 1'b1;
  logic [3:0]  strap = 4'b1010;
  logic        sda_drive_low, freq_from_regs, spread_en, outputs_hiz;
  logic [4:0]  freq_code;
  logic [31:0] out_enable;
  logic [7:0]  aux_cfg;
  wire         sda_line = m_sda & ~sda_drive_low;

  int checks = 0, fails = 0;
  bit cmp_on = 1'b0, finished = 1'b0;

  logic [7:0] exp_r [6];
  logic [3:0] strap_lat;
  logic [7:0] wbuf [16];
  logic [7:0] rbuf [16];

  cfgslv_top u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .strap_i(strap),
    .sda_drive_low(sda_drive_low), .freq_code(freq_code),
    .freq_from_regs(freq_from_regs), .spread_en(spread_en),
    .outputs_hiz(outputs_hiz), .out_enable(out_enable), .aux_cfg(aux_cfg)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [4:0] exp_freq();
    if (exp_r[0][3]) return {exp_r[0][7], exp_r[0][2], exp_r[0][6:4]};
    return {1'b0, strap_lat};
  endfunction

  // revision code 5'b00010 placed per R9
  function automatic logic [7:0] exp_rb(input int k);
    if (k == 0) return 8'd6;
    if (k == 1) return exp_r[0][3] ? exp_r[0] : {1'b0, 3'b010, exp_r[0][3], 1'b0, exp_r[0][1:0]};
    if (k >= 2 && k <= 5) return exp_r[k-1];
    if (k == 6) return {~strap_lat, exp_r[5][3:0]};
    return 8'hFF;
  endfunction

  // reference comparison on every clock while SCL is high
  always @(negedge clk) begin
    if (cmp_on && m_scl) begin
      chk("R7 freq_code", 32'(freq_code), 32'(exp_freq()));
      chk("R7 freq_from_regs", 32'(freq_from_regs), 32'(exp_r[0][3]));
      chk("R8 spread_en", 32'(spread_en), 32'(exp_r[0][1]));
      chk("R8 outputs_hiz", 32'(outputs_hiz), 32'(exp_r[0][0]));
      chk("R11 out_enable", out_enable, {exp_r[4], exp_r[3], exp_r[2], exp_r[1]});
      chk("R11 aux_cfg", 32'(aux_cfg), 32'(exp_r[5]));
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wait_n(H);
    m_scl = 1'b1; wait_n(H);
    m_sda = 1'b0; wait_n(H);
    m_scl = 1'b0;
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wait_n(H);
    m_scl = 1'b1; wait_n(H);
    m_sda = 1'b1; wait_n(H);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      m_sda = b[7-i]; wait_n(H);
      m_scl = 1'b1;   wait_n(H);
      m_scl = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input int commit, output bit ack);
    send_bits(b, 8);
    m_sda = 1'b1; wait_n(H);
    if (commit >= 0 && commit < 6) exp_r[commit] = b;
    m_scl = 1'b1; wait_n(H/2);
    ack = ~sda_line; wait_n(H/2);
    m_scl = 1'b0;
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit nack);
    logic s1, s2;
    m_sda = 1'b1;
    b = 8'h00;
    for (int i = 0; i < 8; i++) begin
      wait_n(H);
      m_scl = 1'b1; wait_n(H/2);
      s1 = sda_line; wait_n(H/4);
      s2 = sda_line;
      chk("R14 sda stable while scl high", 32'(s2), 32'(s1));
      b = {b[6:0], s1};
      wait_n(H/4);
      m_scl = 1'b0;
    end
    m_sda = nack; wait_n(H);
    m_scl = 1'b1; wait_n(H);
    m_scl = 1'b0;
    m_sda = 1'b1;
  endtask

  task automatic do_write(input int n);
    bit ack;
    bus_start();
    send_byte(8'hD2, -1, ack); chk("R1 write address ack", 32'(ack), 1);
    send_byte(8'h5A, -1, ack); chk("R3 command ack", 32'(ack), 1);
    send_byte(8'h99, -1, ack); chk("R3 count ack", 32'(ack), 1);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], i, ack);
      if (i < 6) chk("R3 data ack", 32'(ack), 1);
      else       chk("R12 extra data ack", 32'(ack), 1);
    end
    bus_stop();
  endtask

  // reads count + n bytes after it; last one NACKed
  task automatic do_read(input int n, input bit with_start);
    bit ack;
    if (with_start) bus_start();
    send_byte(8'hD3, -1, ack); chk("R1 read address ack", 32'(ack), 1);
    for (int k = 0; k <= n; k++) begin
      recv_byte(rbuf[k], k == n);
      chk(k > 6 ? "R5 beyond last register" : "R5 R9 R10 readback",
          32'(rbuf[k]), 32'(exp_rb(k)));
    end
    bus_stop();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    bit ack;
    logic [7:0] b;
    exp_r[0] = 8'h00; exp_r[1] = 8'hFF; exp_r[2] = 8'hFF;
    exp_r[3] = 8'hFF; exp_r[4] = 8'hFF; exp_r[5] = 8'h06;
    strap_lat = 4'b1010;
    wait_n(5);
    rst_n = 1'b1;
    wait_n(4);
    cmp_on = 1'b1;
    // R6: reset state seen by the per-clock comparison and by a full read
    chk("R6 sda released after reset", 32'(sda_drive_low), 0);
    wait_n(20);
    do_read(7, 1'b1);

    // R3 R4 R7 R8: header discarded, two data bytes, stop after byte 1
    wbuf[0] = 8'hBB; wbuf[1] = 8'h12;
    do_write(2);
    do_read(6, 1'b1);

    // R12 R9 R10 R11: full bank plus two extra bytes, straps selected
    wbuf[0] = 8'h72; wbuf[1] = 8'hA1; wbuf[2] = 8'hB2; wbuf[3] = 8'hC3;
    wbuf[4] = 8'hD4; wbuf[5] = 8'h3C; wbuf[6] = 8'hEE; wbuf[7] = 8'h77;
    do_write(8);
    do_read(7, 1'b1);

    // R7: strap changes after capture are ignored
    strap = 4'b0101;
    wait_n(40);

    // R2: unknown address, then a byte of zeros, no acknowledge
    bus_start();
    send_byte(8'hA4, -1, ack); chk("R2 foreign address not acked", 32'(ack), 0);
    send_byte(8'h00, -1, ack); chk("R2 line released after foreign address", 32'(ack), 0);
    bus_stop();
    bus_start();
    send_byte(8'hD0, -1, ack); chk("R2 near address not acked", 32'(ack), 0);
    bus_stop();

    // R4: partial byte then STOP is dropped
    bus_start();
    send_byte(8'hD2, -1, ack); send_byte(8'h00, -1, ack); send_byte(8'h00, -1, ack);
    send_bits(8'h0F, 4);
    bus_stop();
    // R4: partial byte then repeated START is dropped
    bus_start();
    send_byte(8'hD2, -1, ack); send_byte(8'h00, -1, ack); send_byte(8'h00, -1, ack);
    send_bits(8'h00, 3);
    bus_start();
    do_read(6, 1'b0);

    // R13: NACK after the count byte, further clocks see a released line
    bus_start();
    send_byte(8'hD3, -1, ack); chk("R1 read address ack", 32'(ack), 1);
    recv_byte(b, 1'b1); chk("R5 count byte", 32'(b), 6);
    recv_byte(b, 1'b1); chk("R13 line released after master NACK", 32'(b), 32'hFF);
    bus_stop();

    // R7 R9: software code selected, readback shows the written value
    wbuf[0] = 8'h4A;
    do_write(1);
    do_read(2, 1'b1);
    wbuf[0] = 8'hF9;
    do_write(1);
    do_read(1, 1'b1);

    wait_n(20);
    finish_run();
  end
endmodule